// File: doc/BRIEF.md
# Bank Group Sequence Analyzer

This block watches the stream of decoded column commands on a DDR4 command bus. It compares every read or write with the column command that came just before it. Back-to-back column accesses to one bank group are held to the longer column-to-column spacing. Accesses that alternate between groups can use the shorter spacing. The block counts how often each of these cases occurs, so software can see how much of the traffic pays the slower same-group penalty.

A command decoder drives one strobe per column command, together with the direction (read or write), the rank and the bank group. Activates, precharges, refreshes and idle cycles never raise the strobe, so they have no effect on the comparison. Four category counters and one total-pairs counter are provided. Software reads them and divides each category by the total to get percentages. All counters saturate at their maximum value. A synchronous clear input restarts the measurement.

Top module: `bg_seq_analyzer`

## Requirements
- R1: After reset all five counters read zero.
- R2: A read whose predecessor was a read to the same rank and bank group increments `rdSameCnt`. A write whose predecessor was a write to the same rank and bank group increments `wrSameCnt`. The new value is visible after the clock edge that samples the strobe.
- R3: A read after a read to a different bank group increments `rdDiffCnt`. A write after a write to a different bank group increments `wrDiffCnt`.
- R4: The first column command after reset or after a clear has no predecessor. It increments no counter, but it becomes the predecessor of the next command.
- R5: A read after a write, or a write after a read, increments no counter. It still replaces the stored predecessor.
- R6: A same-direction pair whose rank differs from the predecessor's rank counts as a different-group pair, even when the bank group numbers are equal.
- R7: Cycles with `cmdValid` low leave the counters and the stored predecessor unchanged. Classification always uses the most recent column command, however many idle cycles lie between the two commands.
- R8: `pairCnt` increments on every cycle in which a category counter is incremented. At most one category counter changes per cycle.
- R9: `clr` high zeroes all counters on the next edge and forgets the predecessor. A column command presented in the same cycle as `clr` is discarded.
- R10: Each counter saturates on its own at 2^CNT_W-1 and stays there until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| clr | input | 1 | Synchronous clear of counters and predecessor |
| cmdValid | input | 1 | One decoded column command this cycle |
| cmdIsWrite | input | 1 | 1 = write, 0 = read |
| cmdRank | input | RANK_W | Rank of the command |
| cmdGroup | input | BG_W | Bank group of the command |
| rdSameCnt | output | CNT_W | Read-after-read, same group |
| wrSameCnt | output | CNT_W | Write-after-write, same group |
| rdDiffCnt | output | CNT_W | Read-after-read, different group or rank |
| wrDiffCnt | output | CNT_W | Write-after-write, different group or rank |
| pairCnt | output | CNT_W | Total classified pairs |

## Verification
On every cycle the assertions check four things. A clear leaves zeros behind it. Idle cycles change no counter. No more than one category moves in a cycle, and the total moves together with the categories. A saturated counter stays at its maximum. The behaviours that depend on what came before can only be shown by the bench's directed command sequences. These are the choice between same and different group, the rank override, the uncounted first command, the uncounted direction changes, and a clear winning over a command in the same cycle.

// File: rtl/bg_seq_pkg.sv
package bg_seq_pkg;
  localparam int NUM_CAT = 4;
  // category index order: 0 rd same, 1 wr same, 2 rd diff, 3 wr diff
  typedef struct packed {
    logic rdSame;
    logic wrSame;
    logic rdDiff;
    logic wrDiff;
    logic clear;
  } bgStrobes_t;
endpackage

// File: rtl/bg_seq_ctrl.sv
module bg_seq_ctrl
  import bg_seq_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int BG_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [RANK_W-1:0] cmdRank,
  input  logic [BG_W-1:0]   cmdGroup,
  output bgStrobes_t        strobes
);
  logic              prevValid;
  logic              prevWrite;
  logic [RANK_W-1:0] prevRank;
  logic [BG_W-1:0]   prevGroup;

  logic live, sameDir, sameLoc;

  always_comb begin
    live    = cmdValid && !clr;
    sameDir = prevValid && (prevWrite == cmdIsWrite);
    sameLoc = (prevRank == cmdRank) && (prevGroup == cmdGroup);
    strobes.rdSame = live && sameDir && !cmdIsWrite &&  sameLoc;
    strobes.wrSame = live && sameDir &&  cmdIsWrite &&  sameLoc;
    strobes.rdDiff = live && sameDir && !cmdIsWrite && !sameLoc;
    strobes.wrDiff = live && sameDir &&  cmdIsWrite && !sameLoc;
    strobes.clear  = clr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevWrite <= 1'b0;
      prevRank  <= '0;
      prevGroup <= '0;
    end else if (clr) begin
      prevValid <= 1'b0;
    end else if (cmdValid) begin
      prevValid <= 1'b1;
      prevWrite <= cmdIsWrite;
      prevRank  <= cmdRank;
      prevGroup <= cmdGroup;
    end
  end
endmodule

// File: rtl/bg_sat_counter.sv
module bg_sat_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rstN)                      value <= '0;
    else if (clr)                   value <= '0;
    else if (inc && value != MAXV)  value <= value + 1'b1;
  end
endmodule

// File: rtl/bg_seq_count.sv
module bg_seq_count
  import bg_seq_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  bgStrobes_t                      strobes,
  output logic [NUM_CAT-1:0][CNT_W-1:0]   catCnt,
  output logic [CNT_W-1:0]                pairCnt
);
  logic [NUM_CAT-1:0] incVec;
  logic               anyInc;

  assign incVec = {strobes.wrDiff, strobes.rdDiff, strobes.wrSame, strobes.rdSame};
  assign anyInc = |incVec;

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
    bg_sat_counter #(.W(CNT_W)) cnt_i (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobes.clear),
      .inc   (incVec[g]),
      .value (catCnt[g])
    );
  end

  bg_sat_counter #(.W(CNT_W)) pair_i (
    .clk   (clk),
    .rstN  (rstN),
    .clr   (strobes.clear),
    .inc   (anyInc),
    .value (pairCnt)
  );
endmodule

// File: rtl/bg_seq_analyzer.sv
module bg_seq_analyzer
  import bg_seq_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int BG_W   = 2,
  parameter int CNT_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              cmdValid,
  input  logic              cmdIsWrite,
  input  logic [RANK_W-1:0] cmdRank,
  input  logic [BG_W-1:0]   cmdGroup,
  output logic [CNT_W-1:0]  rdSameCnt,
  output logic [CNT_W-1:0]  wrSameCnt,
  output logic [CNT_W-1:0]  rdDiffCnt,
  output logic [CNT_W-1:0]  wrDiffCnt,
  output logic [CNT_W-1:0]  pairCnt
);
  bgStrobes_t                      strobes;
  logic [NUM_CAT-1:0][CNT_W-1:0]   catCnt;

  bg_seq_ctrl #(.RANK_W(RANK_W), .BG_W(BG_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .clr        (clr),
    .cmdValid   (cmdValid),
    .cmdIsWrite (cmdIsWrite),
    .cmdRank    (cmdRank),
    .cmdGroup   (cmdGroup),
    .strobes    (strobes)
  );

  bg_seq_count #(.CNT_W(CNT_W)) count_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .catCnt  (catCnt),
    .pairCnt (pairCnt)
  );

  assign rdSameCnt = catCnt[0];
  assign wrSameCnt = catCnt[1];
  assign rdDiffCnt = catCnt[2];
  assign wrDiffCnt = catCnt[3];
endmodule

// File: rtl/bg_seq_checker.sv
module bg_seq_checker #(
  parameter int CNT_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             clr,
  input logic             cmdValid,
  input logic [CNT_W-1:0] rdSameCnt,
  input logic [CNT_W-1:0] wrSameCnt,
  input logic [CNT_W-1:0] rdDiffCnt,
  input logic [CNT_W-1:0] wrDiffCnt,
  input logic [CNT_W-1:0] pairCnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (rdSameCnt == '0 && wrSameCnt == '0 && rdDiffCnt == '0 &&
             wrDiffCnt == '0 && pairCnt == '0));

  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && !cmdValid) |=> ($stable(rdSameCnt) && $stable(wrSameCnt) &&
      $stable(rdDiffCnt) && $stable(wrDiffCnt) && $stable(pairCnt)));

  a_r8_one_category: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> ($countones({rdSameCnt != $past(rdSameCnt), wrSameCnt != $past(wrSameCnt),
                          rdDiffCnt != $past(rdDiffCnt), wrDiffCnt != $past(wrDiffCnt)}) <= 1));

  a_r8_pair_tracks: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && pairCnt != MAXV) |=>
      ((pairCnt != $past(pairCnt)) ==
       ((rdSameCnt != $past(rdSameCnt)) || (wrSameCnt != $past(wrSameCnt)) ||
        (rdDiffCnt != $past(rdDiffCnt)) || (wrDiffCnt != $past(wrDiffCnt)))));

  a_r10_pair_hold_max: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && pairCnt == MAXV) |=> (pairCnt == MAXV));

  a_r10_rdsame_hold_max: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && rdSameCnt == MAXV) |=> (rdSameCnt == MAXV));
endmodule

bind bg_seq_analyzer bg_seq_checker #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clr       (clr),
  .cmdValid  (cmdValid),
  .rdSameCnt (rdSameCnt),
  .wrSameCnt (wrSameCnt),
  .rdDiffCnt (rdDiffCnt),
  .wrDiffCnt (wrDiffCnt),
  .pairCnt   (pairCnt)
);

// File: tb/bg_seq_analyzer_tb.sv
module bg_seq_analyzer_tb_top;
  localparam int RW = 2;
  localparam int GW = 2;
  localparam int CW = 4;
  localparam int MAXC = 15;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clr = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdIsWrite = 1'b0;
  logic [RW-1:0] cmdRank = '0;
  logic [GW-1:0] cmdGroup = '0;
  logic [CW-1:0] rdSameCnt, wrSameCnt, rdDiffCnt, wrDiffCnt, pairCnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bg_seq_analyzer #(.RANK_W(RW), .BG_W(GW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .clr(clr), .cmdValid(cmdValid),
    .cmdIsWrite(cmdIsWrite), .cmdRank(cmdRank), .cmdGroup(cmdGroup),
    .rdSameCnt(rdSameCnt), .wrSameCnt(wrSameCnt), .rdDiffCnt(rdDiffCnt),
    .wrDiffCnt(wrDiffCnt), .pairCnt(pairCnt)
  );

  task automatic checkOne(string req, string name, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  task automatic checkAll(string req, int rs, int ws, int rd, int wd, int pr);
    checkOne(req, "rdSameCnt", int'(rdSameCnt), rs);
    checkOne(req, "wrSameCnt", int'(wrSameCnt), ws);
    checkOne(req, "rdDiffCnt", int'(rdDiffCnt), rd);
    checkOne(req, "wrDiffCnt", int'(wrDiffCnt), wd);
    checkOne(req, "pairCnt",   int'(pairCnt),   pr);
  endtask

  // drive one column command for one cycle, then leave the bus idle
  task automatic sendCmd(bit isWr, int rank, int grp);
    @(negedge clk);
    cmdValid   = 1'b1;
    cmdIsWrite = isWr;
    cmdRank    = RW'(rank);
    cmdGroup   = GW'(grp);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic testReset();
    checkAll("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic testBasicPairs();
    sendCmd(0, 0, 0);
    checkAll("R4", 0, 0, 0, 0, 0);
    sendCmd(0, 0, 0);
    checkAll("R2", 1, 0, 0, 0, 1);
    sendCmd(0, 0, 1);
    checkAll("R3", 1, 0, 1, 0, 2);
    sendCmd(1, 0, 1);
    checkAll("R5", 1, 0, 1, 0, 2);
    sendCmd(1, 0, 1);
    checkAll("R2", 1, 1, 1, 0, 3);
    sendCmd(1, 0, 2);
    checkAll("R3", 1, 1, 1, 1, 4);
  endtask

  task automatic testRankAndIdle();
    sendCmd(1, 1, 2);
    checkAll("R6", 1, 1, 1, 2, 5);
    repeat (6) @(negedge clk);
    checkAll("R7", 1, 1, 1, 2, 5);
    sendCmd(0, 1, 2);
    checkAll("R5", 1, 1, 1, 2, 5);
    repeat (3) @(negedge clk);
    sendCmd(0, 1, 2);
    checkAll("R7", 2, 1, 1, 2, 6);
  endtask

  task automatic testClear();
    pulseClear();
    checkAll("R9", 0, 0, 0, 0, 0);
    sendCmd(0, 1, 2);
    checkAll("R4", 0, 0, 0, 0, 0);
    sendCmd(0, 1, 2);
    checkAll("R9", 1, 0, 0, 0, 1);
    // clear and a command in the same cycle: the command is discarded
    @(negedge clk);
    clr = 1'b1; cmdValid = 1'b1; cmdIsWrite = 1'b0; cmdRank = '0; cmdGroup = 2'd3;
    @(negedge clk);
    clr = 1'b0; cmdValid = 1'b0;
    checkAll("R9", 0, 0, 0, 0, 0);
    sendCmd(0, 0, 3);
    checkAll("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic testSaturate();
    pulseClear();
    @(negedge clk);
    cmdValid = 1'b1; cmdIsWrite = 1'b0; cmdRank = '0; cmdGroup = '0;
    repeat (21) @(negedge clk);
    cmdValid = 1'b0;
    checkAll("R10", MAXC, 0, 0, 0, MAXC);
    sendCmd(1, 0, 0);
    sendCmd(1, 0, 1);
    checkAll("R10", MAXC, 0, 0, 1, MAXC);
    pulseClear();
    checkAll("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic testStreaming();
    // back-to-back commands every cycle: RD g0, RD g1, RD g1, WR g1, WR g0, WR g0
    @(negedge clk);
    cmdValid = 1'b1; cmdIsWrite = 1'b0; cmdRank = '0; cmdGroup = 2'd0;
    @(negedge clk); cmdGroup = 2'd1;
    @(negedge clk); cmdGroup = 2'd1;
    @(negedge clk); cmdIsWrite = 1'b1; cmdGroup = 2'd1;
    @(negedge clk); cmdGroup = 2'd0;
    @(negedge clk); cmdGroup = 2'd0;
    @(negedge clk); cmdValid = 1'b0;
    checkAll("R8", 1, 1, 1, 1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicPairs();
    testRankAndIdle();
    testClear();
    testSaturate();
    testStreaming();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule